// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block lets a processor read a serial NOR flash as if it were ordinary memory. Each word read on a simple request/ready bus becomes a complete flash read sequence. The block drives the chip select for the requested device and sends the opcode and address on one lane. It then clocks the dummy bytes, collects four data bytes on one, two or four lanes, and hands back the 32-bit word. The shape of the command is taken from a template register kept for each chip select. The template holds the opcode, the address length, the dummy byte count and the data lane mode, so one bus can serve flashes that each want a different fast-read command.

A mode switch decides whether this translator owns the flash pins or a separate register-driven command engine does. The switch is visible on an output so that the pin multiplexer outside the block can follow it. A read is refused with an error if it comes in while the switch is off, if it falls outside the mapped window, or if it names a chip select that does not exist. A refused read never touches the pins.

Top module: `mmr_flash_xlat`

## Requirements
- R1: Configuration slot 0 bit 0 is the mode switch and appears on `mm_on`. When it is 0, a bus read gets `rd_ready` one cycle after the request is raised, with `rd_err`=1 and `rd_data`=0, and no chip select is asserted.
- R2: Configuration slot 1+k holds the template for chip select k. Its fields are opcode in bits 7:0, address bytes minus one in bits 9:8, dummy bytes in bits 11:10 and lane mode in bits 13:12. After reset every template is 0x0203, which means opcode 0x03, three address bytes, no dummy bytes and a single lane. Writing one slot leaves the other templates unchanged.
- R3: Each read sends the opcode first and then the low N address bytes, most significant byte first, where N = field+1 (1 to 4). Each byte goes MSB first on `io_out[0]`, and only `io_oe[0]` may be high.
- R4: After the address, the block clocks 8×D dummy bits, where D is the dummy field (0 to 3). The read then ends after exactly 32/L data clocks, where L is the number of data lanes.
- R5: Lane mode 0 samples `io_in[1]`. Mode 1 samples `io_in[1:0]` with bit 1 as the more significant. Mode 3 samples `io_in[3:0]`. The reserved mode 2 behaves as mode 0.
- R6: Each data byte arrives MSB first. The first byte to arrive lands in `rd_data[7:0]` and the fourth in `rd_data[31:24]`.
- R7: A read is refused, as in R1, when `rd_addr`+4 exceeds WINDOW_BYTES or when `rd_cs` ≥ NUM_CS. A read at `rd_addr` = WINDOW_BYTES−4 is accepted.
- R8: While a read is in progress, only the chip select named by `rd_cs` is low. At most one chip select is ever low.
- R9: Between two reads, all chip selects stay high for at least one SCLK period, which is 2×HALF_DIV clock cycles.
- R10: SCLK idles low and changes only while a chip select is low (mode 0). Data is sampled on rising edges and the output shifts on falling edges. `rd_ready` is a single-cycle pulse, and `rd_err` is high only together with it.
- R11: After reset, `rd_ready`, `rd_err`, `mm_on`, `sclk` and `io_oe` are 0, and every chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration slot: 0 switch, 1+k template of chip select k |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_cs | input | CS_W | Chip select index of the read |
| rd_addr | input | ADDR_W | Byte address inside the mapped window |
| rd_ready | output | 1 | One-cycle response strobe |
| rd_data | output | 32 | Returned word |
| rd_err | output | 1 | Read refused |
| mm_on | output | 1 | Pins owned by this translator |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Serial data out, lanes 0 to 3 |
| io_oe | output | 4 | Output enable per lane |
| io_in | input | 4 | Serial data in, lanes 0 to 3 |

## Verification
On every cycle, the bound checker covers the protocol properties of the pins and the bus. It checks that at most one chip select is low and that SCLK stays quiet while all chip selects are high. It checks the length of the deselect gap, that only lane 0 is driven, that the ready pulse is a single cycle and that errors return zero. It also checks that a disabled switch keeps the pins idle. The content of each sequence can only be shown by the bench's flash model: the opcode, the truncated address, the number of dummy clocks, the lane mapping and the byte packing. The model decodes the command the translator sends and answers from a computed memory, across directed templates, window edges and random templates and addresses.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

   typedef enum logic [1:0] {
      LANE_X1  = 2'd0,
      LANE_X2  = 2'd1,
      LANE_RSV = 2'd2,
      LANE_X4  = 2'd3
   } lane_mode_e;

   // packed so that a raw 14-bit write maps onto the fields directly
   typedef struct packed {
      lane_mode_e  lanes;
      logic [1:0]  dummy;
      logic [1:0]  alen_m1;
      logic [7:0]  opcode;
   } setup_t;

   localparam int    SETUP_W   = $bits(setup_t);
   localparam int    CMD_W     = 64;
   localparam logic [SETUP_W-1:0] SETUP_RST = 14'h0203;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_GAP,
      ST_RESP
   } seq_state_e;

   function automatic logic [6:0] cmd_len(setup_t s);
      int n;
      n = 8 * (2 + int'(s.alen_m1) + int'(s.dummy));
      return 7'(n);
   endfunction

   function automatic logic [6:0] data_steps(lane_mode_e m);
      case (m)
         LANE_X2: return 7'd16;
         LANE_X4: return 7'd8;
         default: return 7'd32;
      endcase
   endfunction

   function automatic logic [CMD_W-1:0] build_cmd(setup_t s, logic [31:0] addr);
      logic [31:0] a;
      a = addr << (8 * (3 - int'(s.alen_m1)));
      return {s.opcode, a, 24'h0};
   endfunction

endpackage

// File: rtl/mmr_cfg_regs.sv
module mmr_cfg_regs
   import mmr_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int SEL_W  = 3,
   parameter int CS_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [31:0]      cfg_wdata,
   input  logic [CS_W-1:0]  lookup_cs,
   output logic             mm_on,
   output setup_t           lookup_setup
);

   localparam int FLAT_W = NUM_CS * SETUP_W;

   logic [FLAT_W-1:0] flat;
   logic              unused_hi;

   assign unused_hi = ^cfg_wdata[31:SETUP_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mm_on <= 1'b0;
      else if (cfg_wr && cfg_sel == '0)
         mm_on <= cfg_wdata[0];
   end

   for (genvar k = 0; k < NUM_CS; k++) begin : g_slot
      logic [SETUP_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= SETUP_RST;
         else if (cfg_wr && cfg_sel == SEL_W'(k + 1))
            q <= cfg_wdata[SETUP_W-1:0];
      end
      assign flat[k*SETUP_W +: SETUP_W] = q;
   end

   always_comb begin
      lookup_setup = setup_t'(SETUP_RST);
      for (int k = 0; k < NUM_CS; k++)
         if (int'(lookup_cs) == k)
            lookup_setup = setup_t'(flat[k*SETUP_W +: SETUP_W]);
   end

endmodule

// File: rtl/mmr_sclk_tick.sv
module mmr_sclk_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/mmr_shift_unit.sv
module mmr_shift_unit
   import mmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] load_vec,
   input  logic             shift_tx,
   input  logic             sample_rx,
   input  lane_mode_e       lanes,
   input  logic [3:0]       io_in,
   output logic             tx_bit,
   output logic [31:0]      rx_word
);

   logic [CMD_W-1:0] tx_q;
   logic [31:0]      acc;

   assign tx_bit = tx_q[CMD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= load_vec;
      else if (shift_tx)
         tx_q <= {tx_q[CMD_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (load)
         acc <= '0;
      else if (sample_rx) begin
         case (lanes)
            LANE_X2: acc <= {acc[29:0], io_in[1:0]};
            LANE_X4: acc <= {acc[27:0], io_in};
            default: acc <= {acc[30:0], io_in[1]};
         endcase
      end
   end

   // first byte to arrive sits in acc[31:24]; it belongs in the low byte
   for (genvar b = 0; b < 4; b++) begin : g_swap
      assign rx_word[b*8 +: 8] = acc[(3-b)*8 +: 8];
   end

endmodule

// File: rtl/mmr_flash_xlat.sv
module mmr_flash_xlat
   import mmr_pkg::*;
#(
   parameter int NUM_CS       = 4,
   parameter int ADDR_W       = 24,
   parameter int WINDOW_BYTES = 1 << 20,
   parameter int HALF_DIV     = 2,
   parameter int SEL_W        = $clog2(NUM_CS + 1),
   parameter int CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              rd_req,
   input  logic [CS_W-1:0]   rd_cs,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ready,
   output logic [31:0]       rd_data,
   output logic              rd_err,
   output logic              mm_on,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);

   localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W + 1)'(WINDOW_BYTES);

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_chk_cs
      $error("NUM_CS must lie in 1..8");
   end
   if (ADDR_W < 8 || ADDR_W > 30) begin : g_chk_aw
      $error("ADDR_W must lie in 8..30");
   end
   if (WINDOW_BYTES < 4 || WINDOW_BYTES > (1 << ADDR_W)) begin : g_chk_win
      $error("WINDOW_BYTES must lie in 4..2**ADDR_W");
   end
   if (HALF_DIV < 1 || HALF_DIV > 1000) begin : g_chk_div
      $error("HALF_DIV must lie in 1..1000");
   end
   if (SEL_W < $clog2(NUM_CS + 1) || CS_W < 1 || (1 << CS_W) < NUM_CS) begin : g_chk_w
      $error("SEL_W or CS_W too narrow for NUM_CS");
   end

   seq_state_e        state;
   logic [6:0]        cnt;
   logic              sclk_q;
   logic [NUM_CS-1:0] cs_q;
   lane_mode_e        cur_lanes;
   logic              tick;
   logic              run;
   logic              refuse;
   logic              load;
   logic              shift_tx;
   logic              sample_rx;
   logic              tx_bit;
   logic [31:0]       rx_word;
   setup_t            sel_setup;
   logic [CMD_W-1:0]  cmd_vec;

   mmr_cfg_regs #(
      .NUM_CS (NUM_CS),
      .SEL_W  (SEL_W),
      .CS_W   (CS_W)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .lookup_cs    (rd_cs),
      .mm_on        (mm_on),
      .lookup_setup (sel_setup)
   );

   assign run = (state == ST_CMD) || (state == ST_DATA) || (state == ST_GAP);

   mmr_sclk_tick #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   assign refuse = !mm_on
                || (int'(rd_cs) >= NUM_CS)
                || (({1'b0, rd_addr} + (ADDR_W + 1)'(4)) > WIN_LIM);

   assign load      = (state == ST_IDLE) && rd_req && !refuse;
   assign shift_tx  = (state == ST_CMD)  && tick && sclk_q;
   assign sample_rx = (state == ST_DATA) && tick && !sclk_q;
   assign cmd_vec   = build_cmd(sel_setup, 32'(rd_addr));

   mmr_shift_unit u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_vec  (cmd_vec),
      .shift_tx  (shift_tx),
      .sample_rx (sample_rx),
      .lanes     (cur_lanes),
      .io_in     (io_in),
      .tx_bit    (tx_bit),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sclk_q    <= 1'b0;
         cs_q      <= '1;
         cur_lanes <= LANE_X1;
         rd_ready  <= 1'b0;
         rd_err    <= 1'b0;
         rd_data   <= '0;
      end else begin
         rd_ready <= 1'b0;
         rd_err   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (rd_req) begin
                  if (refuse) begin
                     state    <= ST_RESP;
                     rd_ready <= 1'b1;
                     rd_err   <= 1'b1;
                     rd_data  <= '0;
                  end else begin
                     state       <= ST_CMD;
                     cs_q[rd_cs] <= 1'b0;
                     cnt         <= cmd_len(sel_setup);
                     cur_lanes   <= sel_setup.lanes;
                  end
               end
            end
            ST_CMD: begin
               if (tick) begin
                  if (!sclk_q)
                     sclk_q <= 1'b1;
                  else begin
                     sclk_q <= 1'b0;
                     if (cnt == 7'd1) begin
                        state <= ST_DATA;
                        cnt   <= data_steps(cur_lanes);
                     end else
                        cnt <= cnt - 7'd1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (!sclk_q)
                     sclk_q <= 1'b1;
                  else begin
                     sclk_q <= 1'b0;
                     if (cnt == 7'd1) begin
                        state <= ST_GAP;
                        cs_q  <= '1;
                        cnt   <= 7'd2;
                     end else
                        cnt <= cnt - 7'd1;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (cnt == 7'd1) begin
                     state    <= ST_RESP;
                     rd_ready <= 1'b1;
                     rd_data  <= rx_word;
                  end else
                     cnt <= cnt - 7'd1;
               end
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sclk   = sclk_q;
   assign cs_n   = cs_q;
   assign io_out = {3'b000, (state == ST_CMD) ? tx_bit : 1'b0};
   assign io_oe  = {3'b000, (state == ST_CMD)};

endmodule

// File: rtl/mmr_xlat_chk.sv
module mmr_xlat_chk #(
   parameter int NUM_CS   = 4,
   parameter int HALF_DIV = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_ready,
   input logic              rd_err,
   input logic [31:0]       rd_data,
   input logic              mm_on,
   input logic              sclk,
   input logic [NUM_CS-1:0] cs_n,
   input logic [3:0]        io_oe
);

   localparam logic [15:0] GAP_MIN = 16'(2 * HALF_DIV);

   logic        all_hi;
   logic [15:0] hi_run;

   assign all_hi = &cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_run <= GAP_MIN;
      else if (!all_hi)
         hi_run <= '0;
      else if (hi_run < GAP_MIN)
         hi_run <= hi_run + 16'd1;
   end

   assert_single_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   assert_deselect_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(all_hi) |-> hi_run >= GAP_MIN);

   assert_sclk_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      all_hi |-> !sclk);

   assert_err_with_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> rd_ready);

   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |=> !rd_ready);

   assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> rd_data == 32'h0);

   assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mm_on && all_hi) |=> all_hi);

   assert_lane0_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe[3:1] == 3'b000);

   assert_drive_under_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe[0] |-> !all_hi);

endmodule

bind mmr_flash_xlat mmr_xlat_chk #(
   .NUM_CS   (NUM_CS),
   .HALF_DIV (HALF_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_ready (rd_ready),
   .rd_err   (rd_err),
   .rd_data  (rd_data),
   .mm_on    (mm_on),
   .sclk     (sclk),
   .cs_n     (cs_n),
   .io_oe    (io_oe)
);

// File: tb/tb_mmr_flash_xlat.sv
`timescale 1ns/1ps
module tb_mmr_flash_xlat;

   localparam int NCS = 4;
   localparam int AW  = 24;
   localparam int WIN = 1 << 20;
   localparam int HD  = 2;
   localparam int SW  = $clog2(NCS + 1);
   localparam int CW  = 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cfg_wr;
   logic [SW-1:0]  cfg_sel;
   logic [31:0]    cfg_wdata;
   logic           rd_req;
   logic [CW-1:0]  rd_cs;
   logic [AW-1:0]  rd_addr;
   logic           rd_ready;
   logic [31:0]    rd_data;
   logic           rd_err;
   logic           mm_on;
   logic           sclk;
   logic [NCS-1:0] cs_n;
   logic [3:0]     io_out;
   logic [3:0]     io_oe;
   logic [3:0]     flash_io;

   mmr_flash_xlat #(
      .NUM_CS       (NCS),
      .ADDR_W       (AW),
      .WINDOW_BYTES (WIN),
      .HALF_DIV     (HD)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .rd_req    (rd_req),
      .rd_cs     (rd_cs),
      .rd_addr   (rd_addr),
      .rd_ready  (rd_ready),
      .rd_data   (rd_data),
      .rd_err    (rd_err),
      .mm_on     (mm_on),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .io_out    (io_out),
      .io_oe     (io_oe),
      .io_in     (flash_io)
   );

   always #2 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- bench-side expectations ----------------
   logic [13:0] setup_m [NCS];

   function automatic logic [7:0] mem_b(int cs, logic [31:0] a);
      logic [31:0] v;
      v = (a * 37) ^ ((a >> 8) * 11) ^ (cs * 91) ^ 32'h5C;
      return v[7:0];
   endfunction

   function automatic int lanes_of(logic [1:0] m);
      return (m == 2'd1) ? 2 : (m == 2'd3) ? 4 : 1;
   endfunction

   function automatic int alen_of(logic [13:0] s);
      return int'(s[9:8]) + 1;
   endfunction

   function automatic logic [31:0] trunc(logic [31:0] a, int al);
      return (al == 4) ? a : (a & ((32'h1 << (8 * al)) - 32'h1));
   endfunction

   function automatic logic [31:0] exp_word(int cs, logic [31:0] a);
      return {mem_b(cs, a + 3), mem_b(cs, a + 2), mem_b(cs, a + 1), mem_b(cs, a)};
   endfunction

   // ---------------- flash model ----------------
   logic        all_hi;
   int          bitcnt = 0;
   int          dcount = 0;
   int          m_cs = 0;
   int          m_cmdbits = 64;
   int          m_lanes = 1;
   int          m_steps = 32;
   int          cs_falls = 0;
   int          last_rises = 0;
   logic [63:0] cap;
   logic [7:0]  cap_op;
   logic [31:0] cap_addr;
   logic [31:0] dstream;

   assign all_hi = &cs_n;

   always @(negedge all_hi) begin
      cs_falls++;
      bitcnt = 0;
      dcount = 0;
      m_cs   = 0;
      for (int k = 0; k < NCS; k++) if (!cs_n[k]) m_cs = k;
      m_cmdbits = 8 * (1 + alen_of(setup_m[m_cs]) + int'(setup_m[m_cs][11:10]));
      m_lanes   = lanes_of(setup_m[m_cs][13:12]);
      m_steps   = 32 / m_lanes;
      cap       = '0;
      flash_io  = 4'h0;
   end

   always @(posedge all_hi) last_rises = bitcnt;

   always @(posedge sclk) begin
      if (!all_hi) begin
         if (bitcnt < m_cmdbits) cap = {cap[62:0], io_out[0]};
         bitcnt++;
      end
   end

   always @(negedge sclk) begin : model_drive
      logic [63:0] tmp;
      logic [31:0] grp;
      if (!all_hi && bitcnt >= m_cmdbits && dcount < m_steps) begin
         if (dcount == 0) begin
            cap_op   = cap[m_cmdbits-1 -: 8];
            tmp      = cap >> (8 * int'(setup_m[m_cs][11:10]));
            cap_addr = trunc(tmp[31:0], alen_of(setup_m[m_cs]));
            dstream  = {mem_b(m_cs, cap_addr), mem_b(m_cs, cap_addr + 1),
                        mem_b(m_cs, cap_addr + 2), mem_b(m_cs, cap_addr + 3)};
         end
         grp = (dstream >> (32 - (dcount + 1) * m_lanes)) & ((32'h1 << m_lanes) - 32'h1);
         if (m_lanes == 1) flash_io = {2'b00, grp[0], 1'b0};
         else              flash_io = grp[3:0];
         dcount++;
      end
   end

   // ---------------- bus tasks ----------------
   task automatic cfg_write(input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_sel   = SW'(sel);
      cfg_wdata = d;
      if (sel >= 1) setup_m[sel-1] = d[13:0];
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic bus_read(input int cs, input logic [31:0] a,
                           output logic [31:0] d, output logic e, output int lat);
      @(negedge clk);
      rd_req  = 1'b1;
      rd_cs   = CW'(cs);
      rd_addr = AW'(a);
      lat     = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!rd_ready);
      d = rd_data;
      e = rd_err;
      rd_req = 1'b0;
   endtask

   task automatic good_read(input int cs, input logic [31:0] a);
      logic [31:0] d;
      logic        e;
      int          lat;
      int          al;
      logic [31:0] ta;
      int          exp_rises;
      al = alen_of(setup_m[cs]);
      ta = trunc(a, al);
      exp_rises = 8 * (1 + al + int'(setup_m[cs][11:10])) + 32 / lanes_of(setup_m[cs][13:12]);
      bus_read(cs, a, d, e, lat);
      chk(e == 1'b0, "R7 accepted read flagged error", 64'(e), 64'd0);
      chk(d == exp_word(cs, ta), "R5/R6 data word", 64'(d), 64'(exp_word(cs, ta)));
      chk(cap_op == setup_m[cs][7:0], "R3 opcode", 64'(cap_op), 64'(setup_m[cs][7:0]));
      chk(cap_addr == ta, "R3 address bytes", 64'(cap_addr), 64'(ta));
      chk(last_rises == exp_rises, "R4 clock count", 64'(last_rises), 64'(exp_rises));
      chk(m_cs == cs, "R8 chip select", 64'(m_cs), 64'(cs));
      chk(sclk == 1'b0 && all_hi, "R10 idle pins", 64'({sclk, all_hi}), 64'b01);
   endtask

   task automatic bad_read(input int cs, input logic [31:0] a, input string tag);
      logic [31:0] d;
      logic        e;
      int          lat;
      int          f0;
      f0 = cs_falls;
      bus_read(cs, a, d, e, lat);
      chk(e == 1'b1, {tag, " error flag"}, 64'(e), 64'd1);
      chk(d == 32'h0, {tag, " zero word"}, 64'(d), 64'd0);
      chk(lat == 1, {tag, " answer latency"}, 64'(lat), 64'd1);
      chk(cs_falls == f0, {tag, " no chip select"}, 64'(cs_falls), 64'(f0));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- main ----------------
   initial begin
      void'($urandom(32'h1F0A_55C3));
      rst_n     = 1'b0;
      cfg_wr    = 1'b0;
      cfg_sel   = '0;
      cfg_wdata = '0;
      rd_req    = 1'b0;
      rd_cs     = '0;
      rd_addr   = '0;
      flash_io  = 4'h0;
      for (int k = 0; k < NCS; k++) setup_m[k] = 14'h0203;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk(rd_ready == 0 && rd_err == 0 && mm_on == 0, "R11 bus outputs", 64'({rd_ready, rd_err, mm_on}), 64'd0);
      chk(sclk == 0 && io_oe == 4'h0 && cs_n == '1, "R11 pin outputs", 64'({sclk, io_oe, cs_n}), 64'({1'b0, 4'h0, 4'hF}));

      // R1 switch off refuses
      bad_read(0, 32'h100, "R1 switch off");

      cfg_write(0, 32'h1);
      chk(mm_on == 1'b1, "R1 switch on", 64'(mm_on), 64'd1);

      // R2 reset template on cs0
      good_read(0, 32'h012345);

      // R2 template writes, per chip select
      cfg_write(2, {18'h0, 2'd1, 2'd1, 2'd3, 8'h3B}); // dual, 1 dummy, 4 addr bytes
      cfg_write(3, {18'h0, 2'd3, 2'd3, 2'd0, 8'h6B}); // quad, 3 dummy, 1 addr byte
      cfg_write(4, {18'h0, 2'd2, 2'd2, 2'd1, 8'hA5}); // reserved lane code, 2 dummy
      good_read(1, 32'h0ABCD1);
      good_read(2, 32'h0ABCDE);
      good_read(3, 32'h00F00F);
      good_read(0, 32'h000007);

      // R7 window edges
      good_read(0, WIN - 4);
      bad_read(0, WIN - 3, "R7 window end");
      bad_read(2, 32'hFFFFFF, "R7 window top");

      // random templates and addresses
      for (int i = 0; i < 40; i++) begin
         int cs;
         cs = int'($urandom % NCS);
         if ($urandom % 3 == 0) begin
            logic [31:0] s;
            s = {18'h0, 2'($urandom % 4), 2'($urandom % 4), 2'($urandom % 4), 8'($urandom)};
            cfg_write(cs + 1, s);
         end
         good_read(cs, $urandom % (WIN - 3));
      end

      // R1 switch back off
      cfg_write(0, 32'h0);
      chk(mm_on == 1'b0, "R1 switch off again", 64'(mm_on), 64'd0);
      bad_read(1, 32'h40, "R1 switch cleared");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule